// File: doc/BRIEF.md
# Rotated Tiled View Address Generator

This block turns a pixel position inside a two-dimensional tiled container into the 32-bit address that a memory client presents to the container. The client supplies an X and Y coordinate, a 2-bit pixel format and a 3-bit view orientation. The block returns the address, a flag that says whether the coordinate was inside the container, and the line stride in bytes that belongs to that format and orientation.

Every format leaves a few low coordinate bits unused. The block removes them from the usable X and Y ranges and adds them back as alignment zeros at the bottom of the address. The orientation can mirror either axis and can swap the axes, which gives the eight rotated and mirrored views. The format code and the orientation code are placed in the top five address bits, so a downstream translation stage can decode them.

A parameter adds one output register stage. The valid flag passes through the same stage as the address and the stride.

Top module: `tiled_view_addr_gen`

## Requirements
- R1: For a valid result, address bits [28:27] equal the format code: 0 is 8-bit tiled, 1 is 16-bit tiled, 2 is 32-bit tiled and 3 is page mode.
- R2: For a valid result, address bits [31:29] equal the 3-bit orientation code unchanged. Code 0 is the upright view, 1 is 180° mirrored, 2 is upright mirrored, 3 is 180°, 4 is 270° mirrored, 5 is 270°, 6 is 90° and 7 is 90° mirrored.
- R3: Each format has a pair of shifts (xs, ys). The 8-bit format uses (0,0), 16-bit uses (0,1), 32-bit uses (1,1) and page mode uses (SLOT_W_BITS, SLOT_H_BITS). The usable X width is WIDTH_BITS-xs bits and the usable Y width is HEIGHT_BITS-ys bits.
- R4: If X or Y exceeds its usable all-ones mask, the valid flag is 0 and the address is 0.
- R5: When orientation bit 0 is set, X is replaced by X XOR its usable mask.
- R6: When orientation bit 1 is set, Y is replaced by Y XOR its usable mask.
- R7: When orientation bit 2 is clear, the index is Y*2^(X bits)+X. When bit 2 is set, the index is X*2^(Y bits)+Y.
- R8: The index is multiplied by 2^(xs+ys) and occupies address bits [26:0]. In 16-bit mode bit 0 is therefore 0, and in 32-bit mode bits [1:0] are 0.
- R9: The stride output is 2^(HEIGHT_BITS+xs) when orientation bit 2 is set and 2^(WIDTH_BITS+ys) otherwise. It is reported whether or not the coordinate is valid.
- R10: With OUT_REG=1, all outputs are 0 while reset is low, and each input set appears at the outputs after exactly one rising clock edge. With OUT_REG=0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Pixel format code |
| orient_i | input | 3 | View orientation code |
| x_i | input | COORD_W | X coordinate in pixels |
| y_i | input | COORD_W | Y coordinate in pixels |
| addr_o | output | 32 | Tagged container address |
| valid_o | output | 1 | Coordinate was inside the usable range |
| stride_o | output | 32 | Line stride in bytes for this view |

## Verification
The bench builds the block with its default geometry: a 14-bit width, a 13-bit height, 6-bit slots, 16-bit coordinates and the output register enabled. With these values, page mode shrinks the usable range to 8 by 7 bits, and coordinates one step past each mask, up to 0xFFFF, reach the invalid path in every format. The one-cycle latency is checked on every clock against a queued reference. Each of the four formats is run against all eight orientations at the corner coordinates, so every mirror and swap combination meets the largest and smallest indices and both stride exponents.

// File: rtl/tvag_pkg.sv
package tvag_pkg;

  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } tvag_fmt_e;

  typedef struct packed {
    logic [31:0] addr;
    logic        valid;
    logic [31:0] stride;
  } tvag_out_t;

  localparam int TAG_LSB = 27;

endpackage

// File: rtl/tvag_geom.sv
module tvag_geom
  import tvag_pkg::*;
#(
  parameter int CW  = 14,
  parameter int CH  = 13,
  parameter int SW  = 6,
  parameter int SH  = 6,
  parameter int SHW = 6
) (
  input  tvag_fmt_e      fmt,
  output logic [SHW-1:0] xs,
  output logic [SHW-1:0] ys,
  output logic [SHW-1:0] xb,
  output logic [SHW-1:0] yb,
  output logic [SHW-1:0] al
);

  function automatic logic [SHW-1:0] unused_x(tvag_fmt_e f);
    case (f)
      FMT_B32:  return SHW'(1);
      FMT_PAGE: return SHW'(SW);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [SHW-1:0] unused_y(tvag_fmt_e f);
    case (f)
      FMT_B16, FMT_B32: return SHW'(1);
      FMT_PAGE:         return SHW'(SH);
      default:          return '0;
    endcase
  endfunction

  always_comb begin
    xs = unused_x(fmt);
    ys = unused_y(fmt);
    xb = SHW'(CW) - xs;
    yb = SHW'(CH) - ys;
    al = xs + ys;
  end

endmodule

// File: rtl/tvag_index.sv
module tvag_index #(
  parameter int COORD_W  = 16,
  parameter int IDX_W    = 27,
  parameter int SHW      = 6,
  parameter int XINV_BIT = 0,
  parameter int YINV_BIT = 1,
  parameter int SWAP_BIT = 2
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [2:0]         orient,
  input  logic [SHW-1:0]     xb,
  input  logic [SHW-1:0]     yb,
  output logic [IDX_W-1:0]   idx,
  output logic               in_range,
  output logic               swap
);

  function automatic logic [COORD_W-1:0] low_ones(logic [SHW-1:0] n);
    logic [COORD_W-1:0] m;
    for (int i = 0; i < COORD_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic [COORD_W-1:0] xmask, ymask, xm, ym;

  always_comb begin
    xmask    = low_ones(xb);
    ymask    = low_ones(yb);
    in_range = ((x & ~xmask) == '0) && ((y & ~ymask) == '0);
    xm       = x ^ (orient[XINV_BIT] ? xmask : '0);
    ym       = y ^ (orient[YINV_BIT] ? ymask : '0);
    swap     = orient[SWAP_BIT];
    if (swap) idx = (IDX_W'(xm) << yb) | IDX_W'(ym);
    else      idx = (IDX_W'(ym) << xb) | IDX_W'(xm);
  end

endmodule

// File: rtl/tvag_pack.sv
module tvag_pack
  import tvag_pkg::*;
#(
  parameter int CW    = 14,
  parameter int CH    = 13,
  parameter int IDX_W = 27,
  parameter int SHW   = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [SHW-1:0]   al,
  input  logic [SHW-1:0]   xs,
  input  logic [SHW-1:0]   ys,
  input  tvag_fmt_e        fmt,
  input  logic [2:0]       orient,
  input  logic             in_range,
  input  logic             swap,
  output tvag_out_t        res
);

  localparam int LO_W = TAG_LSB;

  function automatic logic [31:0] stride_of(logic sw, logic [SHW-1:0] sx, logic [SHW-1:0] sy);
    logic [SHW-1:0] e;
    e = sw ? (SHW'(CH) + sx) : (SHW'(CW) + sy);
    return 32'd1 << e;
  endfunction

  logic [LO_W-1:0] lo;

  always_comb begin
    lo         = LO_W'(idx) << al;
    res.addr   = in_range ? {orient, fmt, lo} : 32'd0;
    res.valid  = in_range;
    res.stride = stride_of(swap, xs, ys);
  end

endmodule

// File: rtl/tvag_stage.sv
module tvag_stage #(
  parameter bit REGISTERED = 1'b1,
  parameter int W          = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/tiled_view_addr_gen.sv
module tiled_view_addr_gen
  import tvag_pkg::*;
#(
  parameter int WIDTH_BITS  = 14,
  parameter int HEIGHT_BITS = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16,
  parameter bit OUT_REG     = 1'b1,
  parameter int XINV_BIT    = 0,
  parameter int YINV_BIT    = 1,
  parameter int SWAP_BIT    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         fmt_i,
  input  logic [2:0]         orient_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [31:0]        addr_o,
  output logic               valid_o,
  output logic [31:0]        stride_o
);

  localparam int IDX_W = WIDTH_BITS + HEIGHT_BITS;
  localparam int SHW   = $clog2(IDX_W + SLOT_W_BITS + SLOT_H_BITS + 1);
  localparam int OUT_W = $bits(tvag_out_t);

  tvag_fmt_e        fmt_w;
  logic [SHW-1:0]   xs_w, ys_w, xb_w, yb_w, al_w;
  logic [IDX_W-1:0] idx_w;
  logic             in_range_w, swap_w;
  tvag_out_t        comb_w, out_w;

  assign fmt_w = tvag_fmt_e'(fmt_i);

  tvag_geom #(
    .CW(WIDTH_BITS), .CH(HEIGHT_BITS), .SW(SLOT_W_BITS), .SH(SLOT_H_BITS), .SHW(SHW)
  ) u_geom (
    .fmt(fmt_w), .xs(xs_w), .ys(ys_w), .xb(xb_w), .yb(yb_w), .al(al_w)
  );

  tvag_index #(
    .COORD_W(COORD_W), .IDX_W(IDX_W), .SHW(SHW),
    .XINV_BIT(XINV_BIT), .YINV_BIT(YINV_BIT), .SWAP_BIT(SWAP_BIT)
  ) u_index (
    .x(x_i), .y(y_i), .orient(orient_i), .xb(xb_w), .yb(yb_w),
    .idx(idx_w), .in_range(in_range_w), .swap(swap_w)
  );

  tvag_pack #(
    .CW(WIDTH_BITS), .CH(HEIGHT_BITS), .IDX_W(IDX_W), .SHW(SHW)
  ) u_pack (
    .idx(idx_w), .al(al_w), .xs(xs_w), .ys(ys_w), .fmt(fmt_w), .orient(orient_i),
    .in_range(in_range_w), .swap(swap_w), .res(comb_w)
  );

  tvag_stage #(.REGISTERED(OUT_REG), .W(OUT_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .d(comb_w), .q(out_w)
  );

  assign addr_o   = out_w.addr;
  assign valid_o  = out_w.valid;
  assign stride_o = out_w.stride;

  // Out-of-range coordinates must give a zero address.
  assert_invalid_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> addr_o == 32'd0)
    else $error("R4: invalid result carries nonzero address");

  // Stride is always a single power of two.
  assert_stride_pow2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $countones(stride_o) == 1)
    else $error("R9: stride not a power of two");

  // 32-bit format keeps the two alignment bits clear.
  assert_align_b32_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && addr_o[28:27] == 2'd2) |-> addr_o[1:0] == 2'b00)
    else $error("R8: 32-bit address misaligned");

  generate
    if (OUT_REG) begin : g_chk_reg
      assert_fmt_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> addr_o[28:27] == $past(fmt_i))
        else $error("R1: format tag mismatch");
      assert_view_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> addr_o[31:29] == $past(orient_i))
        else $error("R2: orientation tag mismatch");
    end else begin : g_chk_comb
      assert_fmt_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> addr_o[28:27] == fmt_i)
        else $error("R1: format tag mismatch");
      assert_view_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> addr_o[31:29] == orient_i)
        else $error("R2: orientation tag mismatch");
    end
  endgenerate

endmodule

// File: tb/test_tiled_view_addr_gen.sv
module test_tiled_view_addr_gen;

  localparam int WB = 14;
  localparam int HB = 13;
  localparam int SWB = 6;
  localparam int SHB = 6;
  localparam int CWID = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      fmt = '0;
  logic [2:0]      orient = '0;
  logic [CWID-1:0] x = '0;
  logic [CWID-1:0] y = '0;
  logic [31:0]     addr_o;
  logic            valid_o;
  logic [31:0]     stride_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    longint a;
    bit     v;
    longint s;
    string  tag;
  } exp_t;

  exp_t pending[$];

  always #2 clk = ~clk;

  tiled_view_addr_gen #(
    .WIDTH_BITS(WB), .HEIGHT_BITS(HB), .SLOT_W_BITS(SWB), .SLOT_H_BITS(SHB),
    .COORD_W(CWID), .OUT_REG(1'b1)
  ) i_tiled_view_addr_gen (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .orient_i(orient), .x_i(x), .y_i(y),
    .addr_o(addr_o), .valid_o(valid_o), .stride_o(stride_o)
  );

  function automatic int sx(int f);
    if (f == 2) return 1;
    if (f == 3) return SWB;
    return 0;
  endfunction

  function automatic int sy(int f);
    if (f == 1 || f == 2) return 1;
    if (f == 3) return SHB;
    return 0;
  endfunction

  function automatic exp_t model(int f, int o, int px, int py, string tag);
    exp_t e;
    int xb, yb, xx, yy;
    longint idx;
    xb = WB - sx(f);
    yb = HB - sy(f);
    e.tag = tag;
    e.s = ((o & 4) != 0) ? (64'd1 << (HB + sx(f))) : (64'd1 << (WB + sy(f)));
    if (px >= (1 << xb) || py >= (1 << yb)) begin
      e.v = 0;
      e.a = 0;
      return e;
    end
    xx = ((o & 1) != 0) ? ((1 << xb) - 1 - px) : px;
    yy = ((o & 2) != 0) ? ((1 << yb) - 1 - py) : py;
    if ((o & 4) != 0) idx = longint'(xx) * (64'd1 << yb) + yy;
    else              idx = longint'(yy) * (64'd1 << xb) + xx;
    e.a = longint'(o) * (64'd1 << 29) + longint'(f) * (64'd1 << 27) + idx * (64'd1 << (sx(f) + sy(f)));
    e.v = 1;
    return e;
  endfunction

  task automatic compare_pending();
    exp_t e;
    if (pending.size() == 0) return;
    e = pending.pop_front();
    checks++;
    if (addr_o !== 32'(e.a) || valid_o !== e.v || stride_o !== 32'(e.s)) begin
      failures++;
      $display("FAIL %s: addr=%h valid=%0b stride=%h expected addr=%h valid=%0b stride=%h",
               e.tag, addr_o, valid_o, stride_o, 32'(e.a), e.v, 32'(e.s));
    end
  endtask

  task automatic step(int f, int o, int px, int py, string tag);
    @(negedge clk);
    compare_pending();
    fmt    = 2'(f);
    orient = 3'(o);
    x      = CWID'(px);
    y      = CWID'(py);
    pending.push_back(model(f, o, px, py, tag));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state while inputs are nonzero
    fmt = 2'd2; orient = 3'd5; x = 16'd7; y = 16'd9;
    repeat (3) @(negedge clk);
    checks++;
    if (addr_o !== 32'd0 || valid_o !== 1'b0 || stride_o !== 32'd0) begin
      failures++;
      $display("FAIL R10: reset addr=%h valid=%0b stride=%h expected all zero",
               addr_o, valid_o, stride_o);
    end
    rst_n = 1'b1;

    // R10: one-cycle latency on back-to-back changes
    step(0, 0, 1, 1, "R10");
    step(2, 6, 5, 3, "R10");

    // R1 R2 R3 R5 R6 R7 R8 R9: every format against every view at corners
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 8; o++) begin
        int xm, ym;
        xm = (1 << (WB - sx(f))) - 1;
        ym = (1 << (HB - sy(f))) - 1;
        step(f, o, 0, 0, "R1 R2 R5 R6");
        step(f, o, xm, ym, "R3 R5 R6 R7");
        step(f, o, 3, 5, "R7 R8 R9");
        step(f, o, xm, 0, "R5 R7 R8");
        step(f, o, 0, ym, "R6 R7 R9");
      end
    end

    // R4: one step past each mask and the extreme coordinate
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 8; o += 3) begin
        step(f, o, 1 << (WB - sx(f)), 0, "R4");
        step(f, o, 0, 1 << (HB - sy(f)), "R4");
        step(f, o, 16'hFFFF, 16'hFFFF, "R4");
      end
    end

    // Mixed coordinates near and across the range limits
    for (int k = 0; k < 400; k++) begin
      int f, o, px, py;
      f  = int'($urandom_range(0, 3));
      o  = int'($urandom_range(0, 7));
      px = int'($urandom_range(0, (1 << (WB - sx(f))) + 3));
      py = int'($urandom_range(0, (1 << (HB - sy(f))) + 3));
      step(f, o, px, py, "R3 R4 R7 R9 mixed");
    end

    @(negedge clk);
    compare_pending();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule